// File: doc/BRIEF.md
# FBMC Frequency-Spreading Filter

This block turns a stream of complex OQAM subcarrier values into the frequency-spread sequence used by a filter-bank multicarrier transmitter. Each accepted complex sample is followed by K − 1 zero samples. The resulting stream, K times longer, goes through a prototype filter of 2K − 1 taps. The taps are symmetric about a centre tap of exactly one. The real and imaginary parts are filtered by two identical, independent filter lanes.

The filter is built in transposed form. A stuffed zero only shifts the partial sums along. A real sample needs just K − 1 distinct products, because each product feeds the two taps that share its coefficient. A burst is closed by raising the last flag with its final sample. The block then emits 2K − 2 extra samples so that the filter tail drains. After that the filter state is empty and the next burst starts clean. The upstream source sees `in_ready` low whenever the block is emitting stuffed zeros or tail samples. The output carries a valid strobe and an end-of-burst flag.

Top module: `fbmc_spread`

## Requirements
- R1: While reset is held and right after it, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Each accepted sample yields exactly K output samples in K consecutive cycles. `in_ready` stays low for the K − 1 cycles after the accepting edge.
- R3: With K = 4, the output stream is the convolution of the zero-stuffed input with the taps c[t] = h[|t − 3|], t = 0..6. The values are h[0] = 1 (exact), h[1] = 31849/32768, h[2] = 23170/32768 and h[3] = 7705/32768. Every non-centre product is rounded as (x·q + 16384) >>> 15.
- R4: The output sample of a step is registered on the same clock edge that performs the step. The output for an accepted sample is therefore valid in the cycle right after its accepting edge.
- R5: The imaginary lane uses the same taps and rounding as the real lane. It is computed independently of the real data.
- R6: After a sample accepted with `in_last` = 1 and its K − 1 zeros, exactly 2K − 2 tail samples follow in consecutive cycles, with `in_ready` low. `out_last` is 1 on the final tail sample only, and `in_ready` is 1 in that same cycle.
- R7: Once a burst has completed, the filter state is zero. The next burst's output does not depend on earlier bursts, even when its first sample is offered during the previous tail.
- R8: Outputs are IW + 1 bits wide and never wrap. Full-scale inputs (−32768 and 32767 for IW = 16) give the exact convolution value.
- R9: While idle (`in_ready` high and `in_valid` low), no output sample is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample this cycle |
| in_re | input | IW | Real part of input sample, signed |
| in_im | input | IW | Imaginary part of input sample, signed |
| in_last | input | 1 | Offered sample closes the burst |
| out_valid | output | 1 | Output sample valid |
| out_re | output | IW+1 | Real part of filtered output, signed |
| out_im | output | IW+1 | Imaginary part of filtered output, signed |
| out_last | output | 1 | Final tail sample of a burst |

## Verification
The two functions that can meet in one cycle are the final tail step, which also clears the filter state, and the offer of the first sample of the next burst. The bench provokes this by sending two bursts back to back and holding `in_valid` high through the first burst's stuffed zeros and tail, so that the new sample waits on `in_ready` across the boundary. It then judges the second burst's outputs against a zero-state convolution computed in the bench. It also checks that `out_last` marks only the last tail sample, and that the new sample's acceptance cycle lines up with the start of its outputs.

// File: rtl/fbmc_spread_pkg.sv
package fbmc_spread_pkg;

  // Prototype tap magnitude in Q15 for overlap factor k and tap distance d
  // from the centre. The centre tap (d == 0) is exactly one.
  function automatic int proto_q15(input int k, input int d);
    int q;
    q = 0;
    if (d == 0) q = 32768;
    else begin
      case (k)
        2: if (d == 1) q = 23170;
        3: begin
          if (d == 1) q = 29866;
          if (d == 2) q = 13482;
        end
        4: begin
          if (d == 1) q = 31849;
          if (d == 2) q = 23170;
          if (d == 3) q = 7705;
        end
        default: q = 0;
      endcase
    end
    return q;
  endfunction

  // Product of a sample with a Q15 coefficient, rounded half up.
  function automatic int scale_round(input int x, input int q);
    return int'((longint'(x) * longint'(q) + 64'sd16384) >>> 15);
  endfunction

endpackage

// File: rtl/fbmc_spread_seq.sv
module fbmc_spread_seq #(
  parameter int K = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic ev_accept,
  output logic ev_zero,
  output logic ev_step,
  output logic ev_end
);
  localparam int PW      = $clog2(K);
  localparam int FLUSH_N = 2 * K - 2;
  localparam int FW      = $clog2(FLUSH_N);
  localparam logic [PW-1:0] PH_MAX = PW'(K - 1);
  localparam logic [FW-1:0] F_MAX  = FW'(FLUSH_N - 1);

  logic [PW-1:0] phase_q;
  logic [FW-1:0] fcnt_q;
  logic          flush_q;
  logic          last_pend_q;

  assign in_ready  = (phase_q == '0) && !flush_q;
  assign ev_accept = in_valid && in_ready;
  assign ev_zero   = (phase_q != '0) || flush_q;
  assign ev_step   = ev_accept || ev_zero;
  assign ev_end    = flush_q && (fcnt_q == F_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= '0;
      fcnt_q      <= '0;
      flush_q     <= 1'b0;
      last_pend_q <= 1'b0;
    end else if (ev_accept) begin
      phase_q     <= PW'(1);
      last_pend_q <= in_last;
    end else if (phase_q != '0) begin
      if (phase_q == PH_MAX) begin
        phase_q <= '0;
        if (last_pend_q) begin
          flush_q     <= 1'b1;
          fcnt_q      <= '0;
          last_pend_q <= 1'b0;
        end
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end else if (flush_q) begin
      if (ev_end) begin
        flush_q <= 1'b0;
        fcnt_q  <= '0;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbmc_spread_tfir.sv
module fbmc_spread_tfir #(
  parameter int K  = 4,
  parameter int IW = 16,
  parameter int OW = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 clr,
  input  logic signed [IW-1:0] x,
  output logic signed [OW-1:0] y_q
);
  localparam int NT = 2 * K - 1;
  localparam int NS = NT - 1;

  logic signed [OW-1:0] prod [K];
  logic signed [OW-1:0] tap  [NT];
  logic signed [OW-1:0] st_q [NS];

  // One product per distinct coefficient; the centre tap passes x through.
  assign prod[0] = OW'(x);
  for (genvar d = 1; d < K; d++) begin : g_prod
    assign prod[d] = OW'(fbmc_spread_pkg::scale_round(int'(x),
                        fbmc_spread_pkg::proto_q15(K, d)));
  end

  // Each mirrored tap pair reads the same product.
  for (genvar t = 0; t < NT; t++) begin : g_tap
    localparam int DIST = (t >= K - 1) ? (t - (K - 1)) : ((K - 1) - t);
    assign tap[t] = prod[DIST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
      for (int i = 0; i < NS; i++) st_q[i] <= '0;
    end else if (step) begin
      y_q <= tap[0] + st_q[0];
      if (clr) begin
        for (int i = 0; i < NS; i++) st_q[i] <= '0;
      end else begin
        for (int i = 0; i < NS - 1; i++) st_q[i] <= tap[i+1] + st_q[i+1];
        st_q[NS-1] <= tap[NT-1];
      end
    end
  end

endmodule

// File: rtl/fbmc_spread.sv
module fbmc_spread #(
  parameter int K  = 4,
  parameter int IW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic signed [IW-1:0] in_re,
  input  logic signed [IW-1:0] in_im,
  input  logic              in_last,
  output logic              out_valid,
  output logic signed [IW:0] out_re,
  output logic signed [IW:0] out_im,
  output logic              out_last
);
  localparam int OW = IW + 1;

  // Internal events, named for the checker.
  logic ev_accept;
  logic ev_zero;
  logic ev_step;
  logic ev_end;

  logic signed [IW-1:0] x_re;
  logic signed [IW-1:0] x_im;

  fbmc_spread_seq #(.K(K)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .ev_accept(ev_accept),
    .ev_zero  (ev_zero),
    .ev_step  (ev_step),
    .ev_end   (ev_end)
  );

  assign x_re = ev_zero ? '0 : in_re;
  assign x_im = ev_zero ? '0 : in_im;

  fbmc_spread_tfir #(.K(K), .IW(IW), .OW(OW)) u_fir_re (
    .clk  (clk),
    .rst_n(rst_n),
    .step (ev_step),
    .clr  (ev_end),
    .x    (x_re),
    .y_q  (out_re)
  );

  fbmc_spread_tfir #(.K(K), .IW(IW), .OW(OW)) u_fir_im (
    .clk  (clk),
    .rst_n(rst_n),
    .step (ev_step),
    .clr  (ev_end),
    .x    (x_im),
    .y_q  (out_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= ev_step;
      out_last  <= ev_end;
    end
  end

endmodule

// File: rtl/fbmc_spread_chk.sv
module fbmc_spread_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_last,
  input logic ev_accept,
  input logic ev_zero
);

  // R2: taking a sample closes the input for the following cycle
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !in_ready);

  // R2: every stuffed-zero or tail step yields an output
  a_r2_zero_step_out: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> out_valid);

  // R4: accepted sample is visible on the next cycle
  a_r4_accept_out: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> out_valid);

  // R9: idle cycles produce nothing
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  // R6: end marker reopens the input
  a_r6_last_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> in_ready);

  // R6: end marker lasts one sample
  a_r6_last_once: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_last);

endmodule

bind fbmc_spread fbmc_spread_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_last (out_last),
  .ev_accept(ev_accept),
  .ev_zero  (ev_zero)
);

// File: tb/fbmc_spread_test.sv
module fbmc_spread_test;
  localparam int CLK_PERIOD = 10;
  localparam int K     = 4;
  localparam int IW    = 16;
  localparam int NTAP  = 2 * K - 1;
  localparam int FLUSH = 2 * K - 2;
  localparam int MAXN  = 64;
  localparam int MAXO  = 2 * (MAXN * K + FLUSH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic signed [IW-1:0] in_re = '0;
  logic signed [IW-1:0] in_im = '0;
  logic in_ready;
  logic out_valid;
  logic out_last;
  logic signed [IW:0] out_re;
  logic signed [IW:0] out_im;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ocnt = 0;
  bit done = 1'b0;

  int xr [2*MAXN];
  int xi [2*MAXN];
  int acc_cyc [2*MAXN];
  int o_re [MAXO];
  int o_im [MAXO];
  int o_last [MAXO];
  int o_cyc [MAXO];

  fbmc_spread #(.K(K), .IW(IW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .in_last(in_last),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid) begin
      if (ocnt < MAXO) begin
        o_re[ocnt]   = int'(out_re);
        o_im[ocnt]   = int'(out_im);
        o_last[ocnt] = int'(out_last);
        o_cyc[ocnt]  = cyc;
      end
      ocnt = ocnt + 1;
    end
  end

  // Tap weights restated from the requirement table (R3).
  function automatic int weight(input int t);
    int d;
    d = (t > K - 1) ? t - (K - 1) : (K - 1) - t;
    case (d)
      0: return 32768;
      1: return 31849;
      2: return 23170;
      default: return 7705;
    endcase
  endfunction

  function automatic int rprod(input int x, input int w);
    longint p;
    if (w == 32768) return x;
    p = longint'(x) * longint'(w) + 64'sd16384;
    return int'(p >>> 15);
  endfunction

  // Expected output n of a burst whose samples start at index base.
  function automatic int expect_at(input int n, input int base, input int len, input bit im);
    int acc;
    acc = 0;
    for (int t = 0; t < NTAP; t++) begin
      int m;
      m = n - t;
      if (m >= 0 && (m % K) == 0 && (m / K) < len)
        acc += rprod(im ? xi[base + m/K] : xr[base + m/K], weight(t));
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic send(input int re, input int im, input bit last, input int idx);
    bit rdy;
    in_valid = 1'b1;
    in_re = re[IW-1:0];
    in_im = im[IW-1:0];
    in_last = last;
    do begin
      rdy = in_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!rdy);
    acc_cyc[idx] = cyc;
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic check_seg(input int base, input int len, input int ob, input string tag);
    int nout;
    nout = len * K + FLUSH;
    for (int n = 0; n < nout; n++) begin
      int er;
      int ei;
      int ec;
      er = expect_at(n, base, len, 1'b0);
      ei = expect_at(n, base, len, 1'b1);
      chk(o_re[ob+n] == er, tag, $sformatf("re[%0d]", n), o_re[ob+n], er);
      chk(o_im[ob+n] == ei, "R5", $sformatf("im[%0d]", n), o_im[ob+n], ei);
      chk(o_last[ob+n] == ((n == nout - 1) ? 1 : 0), "R6",
          $sformatf("last[%0d]", n), o_last[ob+n], (n == nout - 1) ? 1 : 0);
      if (n < len * K) begin
        ec = acc_cyc[base + n/K] + (n % K);
        chk(o_cyc[ob+n] == ec, (n % K == 0) ? "R4" : "R2",
            $sformatf("cycle[%0d]", n), o_cyc[ob+n], ec);
      end else begin
        ec = acc_cyc[base + len - 1] + K + (n - len * K);
        chk(o_cyc[ob+n] == ec, "R6", $sformatf("tail cycle[%0d]", n), o_cyc[ob+n], ec);
      end
    end
  endtask

  task automatic run_bursts(input int nseg, input int l0, input int l1,
                            input bit gaps, input string tag);
    int tot;
    int nout;
    tot  = l0 + ((nseg > 1) ? l1 : 0);
    nout = l0 * K + FLUSH + ((nseg > 1) ? l1 * K + FLUSH : 0);
    ocnt = 0;
    for (int i = 0; i < tot; i++) begin
      if (gaps) repeat ($urandom_range(0, 3)) @(negedge clk);
      send(xr[i], xi[i], (i == l0 - 1) || (i == tot - 1), i);
    end
    for (int w = 0; w < 400 && ocnt < nout; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ocnt == nout, "R2", "output count", ocnt, nout);
    if (ocnt == nout) begin
      check_seg(0, l0, 0, tag);
      if (nseg > 1) check_seg(l0, l1, l0 * K + FLUSH, "R7");
    end
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1", "out_last in reset", int'(out_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R9: idle with nothing offered
    ocnt = 0;
    repeat (8) @(negedge clk);
    chk(ocnt == 0, "R9", "idle outputs", ocnt, 0);

    // R3: single impulse shows the tap weights
    xr[0] = 16384; xi[0] = 0;
    run_bursts(1, 1, 0, 1'b0, "R3");

    // R3: random burst with random gaps
    for (int i = 0; i < 24; i++) begin xr[i] = rnd16(); xi[i] = rnd16(); end
    run_bursts(1, 24, 0, 1'b1, "R3");

    // R5: real lane zero, imaginary lane random
    for (int i = 0; i < 16; i++) begin xr[i] = 0; xi[i] = rnd16(); end
    run_bursts(1, 16, 0, 1'b0, "R5");

    // R8: full-scale values
    for (int i = 0; i < 6; i++) begin xr[i] = -32768; xi[i] = 32767; end
    run_bursts(1, 6, 0, 1'b0, "R8");

    // R7: two bursts back to back across the tail
    for (int i = 0; i < 16; i++) begin xr[i] = rnd16(); xi[i] = rnd16(); end
    run_bursts(2, 7, 9, 1'b0, "R3");

    // R9: idle again after traffic
    ocnt = 0;
    repeat (6) @(negedge clk);
    chk(ocnt == 0, "R9", "idle outputs after bursts", ocnt, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule